// File: doc/BRIEF.md
# Selectable Pin Interrupt Controller

This block watches a wide general-purpose input port and turns chosen pins into interrupt requests. It has eight independent slots. Software points each slot at any pin of the port by index and picks how the slot reacts: to a rising edge, a falling edge, both, or a held level of either polarity. Edge events are latched in per-slot sticky flags that software clears by writing ones. Level requests follow the pin directly and latch nothing.

Alongside the slots there is one grouped request for the whole port. Each pin has a group enable bit and a group polarity bit. The grouped request is high whenever at least one enabled pin sits at its programmed level. Every pin passes through a two-flop synchronizer before any of this logic sees it. Software reaches all settings through a simple synchronous write port and a combinational read port.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, every slot configuration reads zero, all edge flags are clear, the group enable mask is zero, and no slot or group request is asserted.
- R2: Slot k is configured at address k (0 to 7). Bits [4:0] hold the pin index. Bit 8 selects level mode (1) or edge mode (0). Bit 9 is the rising enable in edge mode and the slot enable in level mode. Bit 10 is the falling enable in edge mode and selects active-low in level mode. All other bits read back as zero.
- R3: Pins are seen through two flip-flops. Address 11 returns the synchronized pin vector. A pin change is visible there after the second rising clock edge and not after the first.
- R4: In edge mode with the rising enable set, a low-to-high change on the selected pin sets the slot flag. The slot request goes high after the third clock edge that follows the pin change.
- R5: In edge mode, an edge whose direction is not enabled leaves the flag unchanged.
- R6: Address 8 reads the eight edge flags, slot k at bit k. Writing there clears each flag whose data bit is 1 and leaves each flag whose data bit is 0.
- R7: When a new edge and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R8: In level mode with the slot enable set, the slot request is high exactly while the synchronized pin is at the selected polarity. It drops when the pin leaves that level, and the slot flag stays clear.
- R9: Address 9 holds the per-pin group enable mask and address 10 holds the per-pin group polarity, where 1 means active-high. The group request is high when any enabled pin is at its polarity.
- R10: Any pin index 0 to 31 may be chosen, and several slots may select the same pin. Each such slot then reacts independently.
- R11: Pins whose group enable bit is 0 have no effect on the group request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pinIn | input | 32 | Asynchronous port pin levels |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | 4 | Register address for writes and reads |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` (combinational) |
| slotIrq | output | 8 | Per-slot interrupt requests |
| groupIrq | output | 1 | Grouped port interrupt request |

## Verification
On every cycle, the assertions check four things. A flag never clears unless the previous cycle held a clearing write with that bit set. A flag never sets unless the synchronized port changed on the cycle before. The synchronized vector always lags the pins by exactly two clocks. The group request never appears while the enable mask is empty. The behaviours that depend on configuration can only be shown by the bench's scenarios: edge-direction filtering, the set-over-clear race, level tracking with both polarities, the field layout on readback, and per-pin matching within the group.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NUM_SLOTS = 8;
  localparam int ADDR_W    = 4;

  localparam logic [ADDR_W-1:0] FLAG_ADDR = 4'd8;
  localparam logic [ADDR_W-1:0] GEN_ADDR  = 4'd9;
  localparam logic [ADDR_W-1:0] GPOL_ADDR = 4'd10;
  localparam logic [ADDR_W-1:0] PIN_ADDR  = 4'd11;

  // bit positions inside a slot configuration word
  localparam int MODE_BIT = 8;
  localparam int HI_BIT   = 9;
  localparam int LO_BIT   = 10;

  typedef struct packed {
    logic lowEn;      // edge: falling enable, level: active-low select
    logic highEn;     // edge: rising enable, level: slot enable
    logic levelMode;
  } slotMode_t;

  typedef struct packed {
    logic [NUM_SLOTS-1:0] cfgWr;
    logic                 flagClr;
    logic                 grpEnWr;
    logic                 grpPolWr;
  } picStrobe_t;
endpackage

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output picStrobe_t        strobes
);
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slotDec
    assign strobes.cfgWr[k] = wrEn && (addr == ADDR_W'(k));
  end

  assign strobes.flagClr  = wrEn && (addr == FLAG_ADDR);
  assign strobes.grpEnWr  = wrEn && (addr == GEN_ADDR);
  assign strobes.grpPolWr = wrEn && (addr == GPOL_ADDR);
endmodule

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
#(
  parameter int NUM_PINS = 32,
  localparam int SEL_W   = $clog2(NUM_PINS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PINS-1:0]  pinIn,
  input  picStrobe_t           strobes,
  input  logic [NUM_PINS-1:0]  wrData,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [NUM_PINS-1:0]  rdData,
  output logic [NUM_SLOTS-1:0] slotIrq,
  output logic                 groupIrq,
  output logic [NUM_SLOTS-1:0] edgeFlags,
  output logic [NUM_PINS-1:0]  pinSync,
  output logic [NUM_PINS-1:0]  grpEn
);
  logic [NUM_PINS-1:0] syncStage;
  logic [NUM_PINS-1:0] pinPrev;
  logic [NUM_PINS-1:0] grpPol;
  logic [SEL_W-1:0]    slotSel  [NUM_SLOTS];
  slotMode_t           slotMode [NUM_SLOTS];
  logic [NUM_PINS-1:0] cfgWord  [NUM_SLOTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      syncStage <= '0;
      pinSync   <= '0;
      pinPrev   <= '0;
    end else begin
      syncStage <= pinIn;
      pinSync   <= syncStage;
      pinPrev   <= pinSync;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grpEn  <= '0;
      grpPol <= '0;
    end else begin
      if (strobes.grpEnWr)  grpEn  <= wrData;
      if (strobes.grpPolWr) grpPol <= wrData;
    end
  end

  assign groupIrq = |(grpEn & ~(pinSync ^ grpPol));

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    logic curBit, oldBit, edgeHit, levelHit;

    always_ff @(posedge clk) begin
      if (rst) begin
        slotSel[k]  <= '0;
        slotMode[k] <= '0;
      end else if (strobes.cfgWr[k]) begin
        slotSel[k]  <= wrData[SEL_W-1:0];
        slotMode[k] <= '{lowEn: wrData[LO_BIT], highEn: wrData[HI_BIT],
                         levelMode: wrData[MODE_BIT]};
      end
    end

    assign curBit  = pinSync[slotSel[k]];
    assign oldBit  = pinPrev[slotSel[k]];
    assign edgeHit = !slotMode[k].levelMode &&
                     ((slotMode[k].highEn && curBit && !oldBit) ||
                      (slotMode[k].lowEn && !curBit && oldBit));
    assign levelHit = slotMode[k].levelMode && slotMode[k].highEn &&
                      (curBit ^ slotMode[k].lowEn);

    // a fresh edge wins over a clearing write in the same cycle
    always_ff @(posedge clk) begin
      if (rst)                                edgeFlags[k] <= 1'b0;
      else if (edgeHit)                       edgeFlags[k] <= 1'b1;
      else if (strobes.flagClr && wrData[k])  edgeFlags[k] <= 1'b0;
    end

    assign slotIrq[k] = slotMode[k].levelMode ? levelHit : edgeFlags[k];

    always_comb begin
      cfgWord[k]           = '0;
      cfgWord[k][SEL_W-1:0] = slotSel[k];
      cfgWord[k][MODE_BIT] = slotMode[k].levelMode;
      cfgWord[k][HI_BIT]   = slotMode[k].highEn;
      cfgWord[k][LO_BIT]   = slotMode[k].lowEn;
    end
  end

  always_comb begin
    rdData = '0;
    for (int k = 0; k < NUM_SLOTS; k++)
      if (rdAddr == ADDR_W'(k)) rdData = cfgWord[k];
    case (rdAddr)
      FLAG_ADDR: rdData = NUM_PINS'(edgeFlags);
      GEN_ADDR:  rdData = grpEn;
      GPOL_ADDR: rdData = grpPol;
      PIN_ADDR:  rdData = pinSync;
      default:   ;
    endcase
  end
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PINS-1:0]  pinIn,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_PINS-1:0]  wrData,
  output logic [NUM_PINS-1:0]  rdData,
  output logic [NUM_SLOTS-1:0] slotIrq,
  output logic                 groupIrq
);
  picStrobe_t          strobes;
  logic [NUM_SLOTS-1:0] edgeFlags;
  logic [NUM_PINS-1:0]  pinSync;
  logic [NUM_PINS-1:0]  grpEn;

  pic_ctrl u_ctrl (
    .wrEn    (wrEn),
    .addr    (addr),
    .strobes (strobes)
  );

  pic_datapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .pinIn     (pinIn),
    .strobes   (strobes),
    .wrData    (wrData),
    .rdAddr    (addr),
    .rdData    (rdData),
    .slotIrq   (slotIrq),
    .groupIrq  (groupIrq),
    .edgeFlags (edgeFlags),
    .pinSync   (pinSync),
    .grpEn     (grpEn)
  );
endmodule

// File: rtl/pin_irq_checker.sv
module pin_irq_checker
  import pic_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_PINS-1:0]  pinIn,
  input logic                 wrEn,
  input logic [ADDR_W-1:0]    addr,
  input logic [NUM_PINS-1:0]  wrData,
  input logic [NUM_SLOTS-1:0] slotIrq,
  input logic                 groupIrq,
  input logic [NUM_SLOTS-1:0] edgeFlags,
  input logic [NUM_PINS-1:0]  pinSync,
  input logic [NUM_PINS-1:0]  grpEn
);
  logic [1:0]           sinceRst;
  logic [NUM_SLOTS-1:0] clrMask;

  always_ff @(posedge clk) begin
    if (rst)                 sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  assign clrMask = (wrEn && addr == FLAG_ADDR) ? wrData[NUM_SLOTS-1:0] : '0;

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (slotIrq == '0 && !groupIrq && edgeFlags == '0));

  assert_sync_two_stage_R3: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd2) |-> (pinSync == $past(pinIn, 2)));

  assert_flag_needs_edge_R4: assert property (@(posedge clk) disable iff (rst)
    (|(edgeFlags & ~$past(edgeFlags))) |-> ($past(pinSync) != $past(pinSync, 2)));

  assert_flag_clear_by_write_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(edgeFlags) & ~edgeFlags & ~$past(clrMask)) == '0);

  assert_group_needs_enable_R11: assert property (@(posedge clk) disable iff (rst)
    groupIrq |-> (grpEn != '0));
endmodule

bind pin_irq_ctrl pin_irq_checker #(.NUM_PINS(NUM_PINS)) u_checker (
  .clk       (clk),
  .rst       (rst),
  .pinIn     (pinIn),
  .wrEn      (wrEn),
  .addr      (addr),
  .wrData    (wrData),
  .slotIrq   (slotIrq),
  .groupIrq  (groupIrq),
  .edgeFlags (edgeFlags),
  .pinSync   (pinSync),
  .grpEn     (grpEn)
);

// File: tb/pin_irq_ctrl_bench.sv
module pin_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pinIn = '0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [7:0]  slotIrq;
  logic        groupIrq;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  pin_irq_ctrl u_pin_irq_ctrl (
    .clk(clk), .rst(rst), .pinIn(pinIn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .slotIrq(slotIrq), .groupIrq(groupIrq)
  );

  always #10 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks below start and end just after a falling edge
  task automatic waitEdges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic busWrite(logic [3:0] a, logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic busRead(logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic setPin(int idx, logic v);
    pinIn[idx] = v;
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R1 slot requests", 32'(slotIrq), 32'h0);
    check("R1 group request", 32'(groupIrq), 32'h0);
    busRead(4'd0, d); check("R1 slot0 config", d, 32'h0);
    busRead(4'd8, d); check("R1 flags", d, 32'h0);
    busRead(4'd9, d); check("R1 group enable", d, 32'h0);
  endtask

  task automatic testConfigFields();
    logic [31:0] d;
    busWrite(4'd3, 32'h0000_0611);
    busRead(4'd3, d); check("R2 slot3 readback", d, 32'h0000_0611);
    busWrite(4'd5, 32'hFFFF_FFFF);
    busRead(4'd5, d); check("R2 unused bits zero", d, 32'h0000_071F);
    busWrite(4'd3, 32'h0);
    busWrite(4'd5, 32'h0);
  endtask

  task automatic testSync();
    logic [31:0] d;
    pinIn = 32'hA5A5_0000;
    waitEdges(1);
    busRead(4'd11, d); check("R3 not visible after one edge", d, 32'h0);
    waitEdges(1);
    busRead(4'd11, d); check("R3 visible after two edges", d, 32'hA5A5_0000);
    pinIn = '0;
    waitEdges(3);
    busWrite(4'd8, 32'hFF);
  endtask

  task automatic testRising();
    logic [31:0] d;
    busWrite(4'd0, 32'h0000_0204);
    setPin(4, 1'b1);
    waitEdges(2);
    check("R4 not yet after two edges", 32'(slotIrq[0]), 32'h0);
    waitEdges(1);
    check("R4 rising edge sets flag", 32'(slotIrq[0]), 32'h1);
    busRead(4'd8, d); check("R6 flag register", d, 32'h1);
    busWrite(4'd8, 32'h0);
    check("R6 zero write keeps flag", 32'(slotIrq[0]), 32'h1);
    busWrite(4'd8, 32'h1);
    check("R6 one write clears flag", 32'(slotIrq[0]), 32'h0);
    setPin(4, 1'b0);
    waitEdges(3);
    check("R5 falling edge ignored when only rising enabled", 32'(slotIrq[0]), 32'h0);
  endtask

  task automatic testSetWins();
    logic [31:0] d;
    setPin(4, 1'b1);
    waitEdges(2);
    busWrite(4'd8, 32'h1);
    check("R7 set beats clear", 32'(slotIrq[0]), 32'h1);
    busRead(4'd8, d); check("R7 flag still set", d, 32'h1);
    busWrite(4'd8, 32'h1);
    busWrite(4'd0, 32'h0);
    setPin(4, 1'b0);
    waitEdges(3);
  endtask

  task automatic testFalling();
    busWrite(4'd1, 32'h0000_041F);
    setPin(31, 1'b1);
    waitEdges(3);
    check("R5 rising edge ignored when only falling enabled", 32'(slotIrq[1]), 32'h0);
    setPin(31, 1'b0);
    waitEdges(3);
    check("R10 falling edge on pin 31", 32'(slotIrq[1]), 32'h1);
    busWrite(4'd8, 32'h2);
    busWrite(4'd1, 32'h0);
  endtask

  task automatic testLevel();
    logic [31:0] d;
    busWrite(4'd2, 32'h0000_0309);
    check("R8 idle level low", 32'(slotIrq[2]), 32'h0);
    setPin(9, 1'b1);
    waitEdges(2);
    check("R8 level high asserts", 32'(slotIrq[2]), 32'h1);
    busRead(4'd8, d); check("R8 no sticky flag", d, 32'h0);
    setPin(9, 1'b0);
    waitEdges(2);
    check("R8 request drops with pin", 32'(slotIrq[2]), 32'h0);
    busWrite(4'd2, 32'h0000_0709);
    check("R8 active-low level", 32'(slotIrq[2]), 32'h1);
    busWrite(4'd2, 32'h0);
  endtask

  task automatic testGroup();
    busWrite(4'd10, 32'h0000_0008);
    busWrite(4'd9, 32'h0010_0008);
    check("R9 low-polarity pin matches", 32'(groupIrq), 32'h1);
    setPin(20, 1'b1);
    waitEdges(2);
    check("R9 no enabled pin matches", 32'(groupIrq), 32'h0);
    setPin(7, 1'b1);
    waitEdges(2);
    check("R11 disabled pin ignored", 32'(groupIrq), 32'h0);
    setPin(3, 1'b1);
    waitEdges(2);
    check("R9 high-polarity pin matches", 32'(groupIrq), 32'h1);
    busWrite(4'd9, 32'h0);
    check("R11 empty mask", 32'(groupIrq), 32'h0);
    pinIn = '0;
    waitEdges(3);
  endtask

  task automatic testSharedPin();
    busWrite(4'd6, 32'h0000_0200);
    busWrite(4'd7, 32'h0000_0200);
    setPin(0, 1'b1);
    waitEdges(3);
    check("R10 two slots on one pin", 32'(slotIrq[7:6]), 32'h3);
    busWrite(4'd8, 32'h40);
    check("R10 slots clear independently", 32'(slotIrq[7:6]), 32'h2);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    testReset();
    testConfigFields();
    testSync();
    testRising();
    testSetWins();
    testFalling();
    testLevel();
    testGroup();
    testSharedPin();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule